// File: doc/BRIEF.md
# Six-Channel Binary-Weighted PWM Generator

The block holds six identical 8-bit PWM channels that share one timing generator. A prescaler divides the system clock, first by `CLK_DIV` and then by `SEG_LEN`. Each segment therefore lasts `CLK_DIV*SEG_LEN` clocks. With the defaults of 2 and 16 this is 32 clocks, which is 4 µs per segment at 8 MHz. An 8-bit segment index counts through the 256 segments of one period. A shared slot decoder turns that index into eight disjoint slot lines, one per data bit. Bit k owns 2^k segments, and these are spread evenly over the period. Each channel ORs the slots selected by its data bits, so a value v gives exactly v active segments out of 256.

Software reaches the block through a single write port. Channel data sits at offsets 0 to 5. A write takes effect in the channel at once, with no holding register. A control register carries two bits: a halt bit that freezes the timing generator, and a polarity bit shared by all channels. A select register chooses, for each pin, between the PWM waveform and a plain port bit. A direction register gives the output enable for each pin. After reset every enable is off, so all six pins are high-impedance.

Top module: `wpwm_bank`

## Requirements
- R1: After reset, `pin_oe` is 0 on all six pins, `pin_o` is 0, and every channel value, the control register, the select register and the port register read as zero.
- R2: A write to offset i (0..5) replaces the value of channel i only; the other five channels keep their values.
- R3: Over any 256 consecutive segments with constant data and normal polarity, the pin is high in exactly v segments, where v is the channel value (0..255). Segment index 0 activates no bit, so a pin is never high for the whole period.
- R4: Data bit k (0..7) is active in segment s exactly when the low (8-k) bits of s are a 1 followed by (7-k) zeros. The slots of different bits never overlap. For example, bit 7 is active on odd segments, and bit 6 is active on every fourth segment, where s mod 4 = 2.
- R5: Bit 3 of the control register (offset 6) inverts all six PWM outputs. The high count per period then becomes 256-v.
- R6: Bit 0 of the control register (offset 6) is the halt bit. While it is 1, the segment index and the prescaler hold and every PWM output stays constant. Its reset value 0 lets the timing generator run.
- R7: Bit i of the select register (offset 7) routes the PWM waveform to pin i when it is 1. When it is 0, pin i carries bit i of the port register (offset 9).
- R8: Bit i of the direction register (offset 8) drives `pin_oe[i]`. It takes effect on the clock edge that performs the write.
- R9: The segment index advances by one, modulo 256, once every `CLK_DIV*SEG_LEN` clocks while the block is not halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register space |
| wr_addr | input | 4 | Register offset: 0-5 channel data, 6 control, 7 select, 8 direction, 9 port data |
| wr_data | input | 8 | Write data |
| pin_o | output | 6 | Pin output value, PWM or port bit |
| pin_oe | output | 6 | Pin output enable; 0 means high-impedance |

## Verification
A register write lands on the clock edge that samples the strobe. The output enable, the select and the port path follow from the written registers without further delay, so the bench samples them at the next falling edge. The PWM path adds one register after the slot decoder. For this reason the bench lets two falling edges pass after every data or control write and only then starts its measurements. It then counts high samples over exactly 256 consecutive clocks on an instance with one-clock segments. That window covers one whole period whatever its phase, so the count needs no knowledge of the internal segment index. Run lengths on a second instance, whose segments last six clocks, are measured between pin transitions.

// File: rtl/wpwm_pkg.sv
package wpwm_pkg;

    localparam int unsigned CH_N = 6;
    localparam int unsigned RES  = 8;
    localparam int unsigned AW   = 4;

    typedef logic [RES-1:0] duty_t;
    typedef logic [RES-1:0] seg_t;
    typedef logic [RES:0]   wide_t;

    localparam logic [AW-1:0] A_CTRL = AW'(6);
    localparam logic [AW-1:0] A_SEL  = AW'(7);
    localparam logic [AW-1:0] A_DIR  = AW'(8);
    localparam logic [AW-1:0] A_PORT = AW'(9);

    localparam int unsigned CTRL_HALT_BIT = 0;
    localparam int unsigned CTRL_INV_BIT  = 3;

    typedef struct packed {
        logic invert;
        logic halt;
    } ctrl_t;

    // Bit k owns segments whose low (RES-k) bits are 1 followed by zeros.
    function automatic logic slot_hit(input seg_t s, input int unsigned k);
        wide_t mask;
        wide_t want;
        mask = (wide_t'(1) << (RES - k)) - wide_t'(1);
        want = wide_t'(1) << (RES - 1 - k);
        return (wide_t'(s) & mask) == want;
    endfunction

endpackage

// File: rtl/wpwm_timebase.sv
module wpwm_timebase
    import wpwm_pkg::*;
#(
    parameter int unsigned CLK_DIV = 2,
    parameter int unsigned SEG_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output seg_t seg_o,
    output logic seg_adv_o
);

    localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned SW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

    logic half_tick;
    logic seg_adv;
    seg_t seg_q;

    generate
        if (CLK_DIV == 1) begin : g_nodiv
            assign half_tick = run_i;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (run_i) begin
                    div_q <= (div_q == DW'(CLK_DIV - 1)) ? '0 : div_q + DW'(1);
                end
            end
            assign half_tick = run_i && (div_q == DW'(CLK_DIV - 1));
        end

        if (SEG_LEN == 1) begin : g_nosub
            assign seg_adv = half_tick;
        end else begin : g_sub
            logic [SW-1:0] sub_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sub_q <= '0;
                end else if (half_tick) begin
                    sub_q <= (sub_q == SW'(SEG_LEN - 1)) ? '0 : sub_q + SW'(1);
                end
            end
            assign seg_adv = half_tick && (sub_q == SW'(SEG_LEN - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
        end else if (seg_adv) begin
            seg_q <= seg_q + seg_t'(1);
        end
    end

    assign seg_o     = seg_q;
    assign seg_adv_o = seg_adv;

endmodule

// File: rtl/wpwm_slotdec.sv
module wpwm_slotdec
    import wpwm_pkg::*;
(
    input  seg_t           seg_i,
    output logic [RES-1:0] slot_o
);

    generate
        for (genvar k = 0; k < RES; k++) begin : g_slot
            assign slot_o[k] = slot_hit(seg_i, k);
        end
    endgenerate

endmodule

// File: rtl/wpwm_regs.sv
module wpwm_regs
    import wpwm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [RES-1:0]            wr_data,
    output logic [CH_N-1:0][RES-1:0]  duty_o,
    output ctrl_t                     ctrl_o,
    output logic [CH_N-1:0]           sel_o,
    output logic [CH_N-1:0]           dir_o,
    output logic [CH_N-1:0]           port_o
);

    ctrl_t           ctrl_q;
    logic [CH_N-1:0] sel_q;
    logic [CH_N-1:0] dir_q;
    logic [CH_N-1:0] port_q;

    generate
        for (genvar i = 0; i < CH_N; i++) begin : g_duty
            duty_t val_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    val_q <= '0;
                end else if (wr_en && wr_addr == AW'(i)) begin
                    val_q <= wr_data;
                end
            end
            assign duty_o[i] = val_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            dir_q  <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl_q.halt   <= wr_data[CTRL_HALT_BIT];
                    ctrl_q.invert <= wr_data[CTRL_INV_BIT];
                end
                A_SEL:  sel_q  <= wr_data[CH_N-1:0];
                A_DIR:  dir_q  <= wr_data[CH_N-1:0];
                A_PORT: port_q <= wr_data[CH_N-1:0];
                default: ;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;
    assign sel_o  = sel_q;
    assign dir_o  = dir_q;
    assign port_o = port_q;

endmodule

// File: rtl/wpwm_channel.sv
module wpwm_channel
    import wpwm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  duty_t          duty_i,
    input  logic [RES-1:0] slot_i,
    input  logic           invert_i,
    input  logic           sel_i,
    input  logic           port_i,
    input  logic           dir_i,
    output logic           wave_o,
    output logic           pin_o,
    output logic           oe_o
);

    logic pwm_q;

    assign wave_o = |(duty_i & slot_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= wave_o ^ invert_i;
        end
    end

    assign pin_o = sel_i ? pwm_q : port_i;
    assign oe_o  = dir_i;

endmodule

// File: rtl/wpwm_bank.sv
module wpwm_bank
    import wpwm_pkg::*;
#(
    parameter int unsigned CLK_DIV = 2,
    parameter int unsigned SEG_LEN = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [RES-1:0]  wr_data,
    output logic [CH_N-1:0] pin_o,
    output logic [CH_N-1:0] pin_oe
);

    logic [CH_N-1:0][RES-1:0] duty_vec;
    ctrl_t                    ctrl;
    logic [CH_N-1:0]          sel_vec;
    logic [CH_N-1:0]          dir_vec;
    logic [CH_N-1:0]          port_vec;
    seg_t                     seg_idx;
    logic                     seg_adv;
    logic [RES-1:0]           slot_vec;
    logic [CH_N-1:0]          wave_vec;

    wpwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .duty_o  (duty_vec),
        .ctrl_o  (ctrl),
        .sel_o   (sel_vec),
        .dir_o   (dir_vec),
        .port_o  (port_vec)
    );

    wpwm_timebase #(
        .CLK_DIV (CLK_DIV),
        .SEG_LEN (SEG_LEN)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .run_i     (!ctrl.halt),
        .seg_o     (seg_idx),
        .seg_adv_o (seg_adv)
    );

    wpwm_slotdec u_slotdec (
        .seg_i  (seg_idx),
        .slot_o (slot_vec)
    );

    generate
        for (genvar i = 0; i < CH_N; i++) begin : g_ch
            wpwm_channel u_ch (
                .clk      (clk),
                .rst      (rst),
                .duty_i   (duty_vec[i]),
                .slot_i   (slot_vec),
                .invert_i (ctrl.invert),
                .sel_i    (sel_vec[i]),
                .port_i   (port_vec[i]),
                .dir_i    (dir_vec[i]),
                .wave_o   (wave_vec[i]),
                .pin_o    (pin_o[i]),
                .oe_o     (pin_oe[i])
            );
        end
    endgenerate

endmodule

// File: rtl/wpwm_bank_chk.sv
module wpwm_bank_chk
    import wpwm_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [AW-1:0]            wr_addr,
    input logic [RES-1:0]           wr_data,
    input logic [CH_N-1:0]          pin_oe,
    input seg_t                     seg,
    input logic                     seg_adv,
    input logic                     halt,
    input logic [RES-1:0]           slot,
    input logic [CH_N-1:0]          wave,
    input logic [CH_N-1:0][RES-1:0] duty
);

    assert_slot_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot));

    assert_msb_odd_R4: assert property (@(posedge clk) disable iff (rst)
        (seg[0] && duty[0][RES-1]) |-> wave[0]);

    assert_seg_zero_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (seg == '0) |-> (wave == '0));

    assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(seg));

    assert_seg_step_R9: assert property (@(posedge clk) disable iff (rst)
        seg_adv |=> (seg == seg_t'($past(seg) + seg_t'(1))));

    assert_oe_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DIR) |=> (pin_oe == $past(wr_data[CH_N-1:0])));

endmodule

bind wpwm_bank wpwm_bank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pin_oe  (pin_oe),
    .seg     (seg_idx),
    .seg_adv (seg_adv),
    .halt    (ctrl.halt),
    .slot    (slot_vec),
    .wave    (wave_vec),
    .duty    (duty_vec)
);

// File: tb/wpwm_bank_bench.sv
`timescale 1ns/1ps
module wpwm_bank_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] pin_a, oe_a, pin_b, oe_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // channel, value: expected high count equals value (R2, R3)
    localparam int TV [6][2] = '{'{1, 85}, '{2, 170}, '{3, 255},
                                 '{4, 0},  '{5, 1},   '{0, 128}};

    always #4 clk = ~clk;

    wpwm_bank #(.CLK_DIV(1), .SEG_LEN(1)) u_wpwm_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_o(pin_a), .pin_oe(oe_a));

    wpwm_bank #(.CLK_DIV(2), .SEG_LEN(3)) u_wpwm_bank_div (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_o(pin_b), .pin_oe(oe_b));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_hi(input int ch, output int n);
        repeat (2) @(negedge clk);
        n = 0;
        for (int t = 0; t < 256; t++) begin
            @(negedge clk);
            n += int'(pin_a[ch]);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int n, run, guard, changes;
        logic v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", int'(oe_a), 0);
        chk("R1 pin after reset", int'(pin_a), 0);
        chk("R1 oe after reset (div)", int'(oe_b), 0);

        wr(4'd8, 8'h3F);
        chk("R8 oe all enabled", int'(oe_a), 63);
        wr(4'd7, 8'h3F);
        count_hi(0, n);
        chk("R1 channel data reset to zero", n, 0);

        // table of stimulus vectors
        for (int i = 0; i < 6; i++) begin
            wr(4'(TV[i][0]), 8'(TV[i][1]));
            count_hi(TV[i][0], n);
            chk("R3 high count per period", n, TV[i][1]);
        end
        for (int i = 0; i < 6; i++) begin
            count_hi(TV[i][0], n);
            chk("R2 channel kept its value", n, TV[i][1]);
        end

        // R9: six-clock segments on the divided instance, value 0x80 on channel 0
        guard = 0;
        while (pin_b[0] !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (pin_b[0] !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        run = 0;
        while (pin_b[0] === 1'b1 && run < 50) begin run++; @(negedge clk); end
        chk("R9 high run length", run, 6);
        run = 0;
        while (pin_b[0] === 1'b0 && run < 50) begin run++; @(negedge clk); end
        chk("R9 low run length", run, 6);

        // R4: bit 6 alone is high every fourth segment
        wr(4'd0, 8'h40);
        repeat (2) @(negedge clk);
        guard = 0;
        while (pin_a[0] !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (pin_a[0] !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        for (int t = 1; t < 16; t++) begin
            @(negedge clk);
            chk("R4 bit6 slot spacing", int'(pin_a[0]), (t % 4 == 0) ? 1 : 0);
        end

        // R6: halt freezes the waveform
        wr(4'd0, 8'h80);
        wr(4'd6, 8'h01);
        repeat (2) @(negedge clk);
        v = pin_a[0];
        changes = 0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (pin_a[0] !== v) changes++;
        end
        chk("R6 output frozen while halted", changes, 0);
        wr(4'd6, 8'h00);
        count_hi(0, n);
        chk("R6 running again after halt release", n, 128);

        // R7: port path
        wr(4'd9, 8'h01);
        wr(4'd7, 8'h3E);
        n = 0;
        for (int t = 0; t < 20; t++) begin @(negedge clk); n += int'(pin_a[0]); end
        chk("R7 pin follows port bit 1", n, 20);
        wr(4'd9, 8'h00);
        n = 0;
        for (int t = 0; t < 20; t++) begin @(negedge clk); n += int'(pin_a[0]); end
        chk("R7 pin follows port bit 0", n, 0);
        count_hi(1, n);
        chk("R7 other pin still PWM", n, 85);
        wr(4'd7, 8'h3F);

        // R8: partial direction
        wr(4'd8, 8'h15);
        chk("R8 oe pattern", int'(oe_a), 21);
        wr(4'd8, 8'h3F);

        // R3 / R5: full sweep with both polarities
        for (int pol = 0; pol < 2; pol++) begin
            wr(4'd6, (pol != 0) ? 8'h08 : 8'h00);
            for (int val = 0; val < 256; val++) begin
                wr(4'd0, 8'(val));
                count_hi(0, n);
                if (pol != 0) chk("R5 inverted high count", n, 256 - val);
                else          chk("R3 sweep high count", n, val);
            end
        end

        summary();
    end

endmodule